// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block models a synchronous static memory whose command, address and byte selects are captured on one rising clock edge. The matching data transfer happens two edges later, and that delay is the same for reads and writes. Because both operation types share that delay, a controller can issue any mix of reads and writes on consecutive cycles and the shared data bus never needs an idle turnaround cycle. Each word is made of byte lanes of 8 data bits plus one extra bit. Byte lanes can be written selectively.

A single command can also start a four-word burst. On later cycles an advance control steps an internal counter through the aligned four-word group. A static select picks either a wrapping-increment order or an XOR order. A clock enable freezes the whole pipeline. Three chip selects gate new commands without cancelling those already in flight. An asynchronous output enable can float the bus at any moment. Reads come from an inferred block RAM with a registered read port. Bypass paths make a read that closely follows a write to the same word return the new data.

Top module: `zbt_sram`

## Requirements
- R1: A command sampled at rising edge k has its data phase in the cycle that ends at edge k+2. Read data is driven on `dq` after edge k+1, and write data is captured from `dq` at edge k+2.
- R2: Reads and writes may be issued on every cycle in any order with no idle cycles. A read of a word written by either of the two preceding commands returns the newly written bytes.
- R3: On a write, lane i occupies bits [9i+8:9i] and is stored only when `bw_n[i]` is 0 for that command. Lanes whose select is 1 keep their old content.
- R4: On a load (`adv_ld_n`=0), a new operation starts only when `ce1_n`=0, `ce2`=1 and `ce3_n`=0. Otherwise no operation starts, memory is unchanged, and the bus is undriven in that command's data phase.
- R5: A read or write already issued still completes its data phase when the following commands deselect the device.
- R6: With `adv_ld_n`=1, the next word of the current burst is accessed with the operation type of its load. Step n (n=0..3, counting modulo 4) uses low address bits (s+n) mod 4 when `burst_linear`=1, and s XOR n when it is 0, where s is the loaded low two bits. The upper address bits are kept. An advance after a deselecting load performs no operation.
- R7: While `cen_n`=1, all synchronous inputs are ignored and all pipeline state holds. This includes the driven read data and the pending write capture, which moves to the next enabled edge.
- R8: `dq` is driven only during a read data phase while `oe_n`=0. `oe_n`=1 releases the bus immediately, without waiting for a clock edge.
- R9: A synchronous active-high `rst` cancels all pending operations, so the bus is undriven after reset.
- R10: On a load, `we_n`=1 selects a read and `we_n`=0 selects a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cen_n | input | 1 | Clock enable, active low; high stalls the pipeline |
| ce1_n | input | 1 | Chip select, active low |
| ce2 | input | 1 | Chip select, active high |
| ce3_n | input | 1 | Chip select, active low |
| adv_ld_n | input | 1 | 0 loads a new command, 1 advances the burst |
| we_n | input | 1 | Operation type on load: 1 read, 0 write |
| bw_n | input | NBYTE | Per-lane write selects, active low |
| addr | input | ADDR_W | Word address |
| burst_linear | input | 1 | Static burst order: 1 wrapping increment, 0 XOR |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dq | inout | NBYTE*BYTE_W | Bidirectional data bus |

## Verification
The bench first fills every word with distinct arithmetic patterns and reads all of them back in a continuous stream. This shows that the two-cycle data phase lines up per address. It then alternates writes and reads to the same word at distances of one and two commands, which separates the live-bus bypass from the registered-write bypass and from a plain memory read. Next it sweeps all sixteen lane masks over a known word, then runs bursts from every start offset in both orders, wrapping past four words. Finally, deselect patterns, stall runs carrying an ignored write, and output-enable pulses show whether an ignored command leaks into memory or onto the bus, with a full readback at the end.

// File: rtl/zbt_pkg.sv
package zbt_pkg;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

  // Low address bits for step n of a four-word burst
  function automatic logic [1:0] burst_offset(input logic [1:0] start,
                                              input logic [1:0] step,
                                              input logic       linear);
    return linear ? (start + step) : (start ^ step);
  endfunction

endpackage

// File: rtl/zbt_cmd_ctrl.sv
module zbt_cmd_ctrl
  import zbt_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int NBYTE  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cen_n,
  input  logic              ce1_n,
  input  logic              ce2,
  input  logic              ce3_n,
  input  logic              adv_ld_n,
  input  logic              we_n,
  input  logic [NBYTE-1:0]  bw_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              burst_linear,
  output logic [ADDR_W-1:0] cmd_addr,
  output op_e               s1_op,
  output logic [ADDR_W-1:0] s1_addr,
  output logic [NBYTE-1:0]  s1_bm
);

  logic              sel;
  op_e               nxt_op;
  op_e               bst_op;
  logic [ADDR_W-1:0] bst_base;
  logic [1:0]        burst_cnt;
  logic [1:0]        nxt_cnt;

  assign sel = !ce1_n && ce2 && !ce3_n;

  always_comb begin
    if (!adv_ld_n) begin
      nxt_op   = sel ? (we_n ? OP_READ : OP_WRITE) : OP_NONE;
      nxt_cnt  = 2'd0;
      cmd_addr = addr;
    end else begin
      nxt_op   = bst_op;
      nxt_cnt  = burst_cnt + 2'd1;
      cmd_addr = {bst_base[ADDR_W-1:2],
                  burst_offset(bst_base[1:0], nxt_cnt, burst_linear)};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bst_op    <= OP_NONE;
      bst_base  <= '0;
      burst_cnt <= '0;
      s1_op     <= OP_NONE;
      s1_addr   <= '0;
      s1_bm     <= '0;
    end else if (!cen_n) begin
      if (!adv_ld_n) begin
        bst_op   <= nxt_op;
        bst_base <= addr;
      end
      burst_cnt <= nxt_cnt;
      s1_op     <= nxt_op;
      s1_addr   <= cmd_addr;
      s1_bm     <= ~bw_n;
    end
  end

  AST_DESEL_NO_OP: assert property (@(posedge clk) disable iff (rst)
    (!cen_n && !adv_ld_n && !sel) |=> (s1_op == OP_NONE)); // R4

  AST_BURST_IN_GROUP: assert property (@(posedge clk) disable iff (rst)
    (!cen_n && adv_ld_n) |=> (s1_addr[ADDR_W-1:2] == $past(s1_addr[ADDR_W-1:2]))); // R6

  AST_CMD_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (rst)
    cen_n |=> ($stable(s1_op) && $stable(s1_addr) && $stable(burst_cnt))); // R7

endmodule

// File: rtl/zbt_mem_array.sv
module zbt_mem_array #(
  parameter int ADDR_W = 6,
  parameter int NBYTE  = 4,
  parameter int BYTE_W = 9
) (
  input  logic                    clk,
  input  logic                    en,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [NBYTE*BYTE_W-1:0] rd_data,
  input  logic                    we,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [NBYTE-1:0]        wr_bm,
  input  logic [NBYTE*BYTE_W-1:0] wr_data
);

  localparam int DEPTH  = 1 << ADDR_W;
  localparam int WORD_W = NBYTE * BYTE_W;

  logic [WORD_W-1:0] mem [DEPTH];

  // Read-first dual-port RAM with per-lane write enables
  always_ff @(posedge clk) begin
    if (en) begin
      rd_data <= mem[rd_addr];
      for (int b = 0; b < NBYTE; b++) begin
        if (we && wr_bm[b]) begin
          mem[wr_addr][b*BYTE_W +: BYTE_W] <= wr_data[b*BYTE_W +: BYTE_W];
        end
      end
    end
  end

endmodule

// File: rtl/zbt_out_stage.sv
module zbt_out_stage
  import zbt_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int NBYTE  = 4,
  parameter int BYTE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  op_e                     s1_op,
  input  logic [ADDR_W-1:0]       s1_addr,
  input  logic [NBYTE*BYTE_W-1:0] rd_raw,
  input  op_e                     s2_op,
  input  logic [ADDR_W-1:0]       s2_addr,
  input  logic [NBYTE-1:0]        s2_bm,
  input  logic [NBYTE*BYTE_W-1:0] wr_data,
  output logic [NBYTE*BYTE_W-1:0] dout,
  output logic                    dout_valid
);

  localparam int WORD_W = NBYTE * BYTE_W;

  logic              wb_valid;
  logic [ADDR_W-1:0] wb_addr;
  logic [NBYTE-1:0]  wb_bm;
  logic [WORD_W-1:0] wb_data;
  logic              wb_hit;
  logic              live_hit;
  logic [WORD_W-1:0] merged;

  assign wb_hit   = wb_valid && (wb_addr == s1_addr);
  assign live_hit = (s2_op == OP_WRITE) && (s2_addr == s1_addr);

  // Older write (registered) first, then the write being captured now
  always_comb begin
    merged = rd_raw;
    for (int b = 0; b < NBYTE; b++) begin
      if (wb_hit && wb_bm[b]) begin
        merged[b*BYTE_W +: BYTE_W] = wb_data[b*BYTE_W +: BYTE_W];
      end
      if (live_hit && s2_bm[b]) begin
        merged[b*BYTE_W +: BYTE_W] = wr_data[b*BYTE_W +: BYTE_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dout_valid <= 1'b0;
      dout       <= '0;
      wb_valid   <= 1'b0;
      wb_addr    <= '0;
      wb_bm      <= '0;
      wb_data    <= '0;
    end else if (en) begin
      dout_valid <= (s1_op == OP_READ);
      if (s1_op == OP_READ) begin
        dout <= merged;
      end
      wb_valid <= (s2_op == OP_WRITE);
      wb_addr  <= s2_addr;
      wb_bm    <= s2_bm;
      wb_data  <= wr_data;
    end
  end

  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (en && s1_op == OP_READ) |=> dout_valid); // R1

  AST_OUT_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(dout) && $stable(dout_valid))); // R7

endmodule

// File: rtl/zbt_sram.sv
module zbt_sram
  import zbt_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int NBYTE  = 4,
  parameter int BYTE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cen_n,
  input  logic                    ce1_n,
  input  logic                    ce2,
  input  logic                    ce3_n,
  input  logic                    adv_ld_n,
  input  logic                    we_n,
  input  logic [NBYTE-1:0]        bw_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    burst_linear,
  input  logic                    oe_n,
  inout  wire  [NBYTE*BYTE_W-1:0] dq
);

  localparam int WORD_W = NBYTE * BYTE_W;

  logic              en;
  logic [ADDR_W-1:0] cmd_addr;
  op_e               s1_op;
  logic [ADDR_W-1:0] s1_addr;
  logic [NBYTE-1:0]  s1_bm;
  op_e               s2_op;
  logic [ADDR_W-1:0] s2_addr;
  logic [NBYTE-1:0]  s2_bm;
  logic [WORD_W-1:0] rd_raw;
  logic [WORD_W-1:0] dout;
  logic              dout_valid;
  logic              drive_en;
  logic              mem_we;

  assign en = !cen_n;

  zbt_cmd_ctrl #(.ADDR_W(ADDR_W), .NBYTE(NBYTE)) u_ctrl (
    .clk, .rst, .cen_n, .ce1_n, .ce2, .ce3_n, .adv_ld_n, .we_n, .bw_n,
    .addr, .burst_linear, .cmd_addr, .s1_op, .s1_addr, .s1_bm
  );

  // Second command stage: its data phase is the next enabled edge
  always_ff @(posedge clk) begin
    if (rst) begin
      s2_op   <= OP_NONE;
      s2_addr <= '0;
      s2_bm   <= '0;
    end else if (en) begin
      s2_op   <= s1_op;
      s2_addr <= s1_addr;
      s2_bm   <= s1_bm;
    end
  end

  assign mem_we = (s2_op == OP_WRITE);

  zbt_mem_array #(.ADDR_W(ADDR_W), .NBYTE(NBYTE), .BYTE_W(BYTE_W)) u_mem (
    .clk, .en, .rd_addr(cmd_addr), .rd_data(rd_raw),
    .we(mem_we), .wr_addr(s2_addr), .wr_bm(s2_bm), .wr_data(dq)
  );

  zbt_out_stage #(.ADDR_W(ADDR_W), .NBYTE(NBYTE), .BYTE_W(BYTE_W)) u_out (
    .clk, .rst, .en, .s1_op, .s1_addr, .rd_raw, .s2_op, .s2_addr, .s2_bm,
    .wr_data(dq), .dout, .dout_valid
  );

  assign drive_en = dout_valid && !oe_n;
  assign dq       = drive_en ? dout : 'z;

  AST_NO_BUS_FIGHT: assert property (@(posedge clk) disable iff (rst)
    !(dout_valid && s2_op == OP_WRITE)); // R2

  AST_PENDING_SURVIVES_DESEL: assert property (@(posedge clk) disable iff (rst)
    (en && s1_op != OP_NONE) |=> (s2_op == $past(s1_op))); // R5

endmodule

// File: tb/sim_zbt_sram.sv
module sim_zbt_sram;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 5;
  localparam int NBYTE  = 4;
  localparam int BYTE_W = 9;
  localparam int W      = NBYTE * BYTE_W;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam logic [2:0] SEL = 3'b010;  // {ce1_n, ce2, ce3_n}

  logic clk = 1'b0;
  logic rst, cen_n, ce1_n, ce2, ce3_n, adv_ld_n, we_n, burst_linear, oe_n;
  logic [NBYTE-1:0]  bw_n;
  logic [ADDR_W-1:0] addr;
  logic [W-1:0]      tb_dq;
  logic              tb_drv;
  wire  [W-1:0]      dq;

  assign dq = tb_drv ? tb_dq : 'z;
  for (genvar i = 0; i < W; i++) begin : g_pu
    pullup (dq[i]);
  end

  zbt_sram #(.ADDR_W(ADDR_W), .NBYTE(NBYTE), .BYTE_W(BYTE_W)) u0 (
    .clk, .rst, .cen_n, .ce1_n, .ce2, .ce3_n, .adv_ld_n, .we_n, .bw_n,
    .addr, .burst_linear, .oe_n, .dq
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // Bench model
  logic [W-1:0] mdl [DEPTH];
  int   m_bop, m_base, m_cnt;
  int   p_op, p_addr; logic [NBYTE-1:0] p_bm;
  int   h0_op, h0_addr; logic [NBYTE-1:0] h0_bm;
  int   h1_op, h1_addr; logic [NBYTE-1:0] h1_bm;
  bit   adv_prev;
  bit   oe_probe;
  logic [63:0] lcg = 64'h1234_5678_9abc_def1;
  logic [W-1:0] wd;

  task automatic chk(input logic ok, input string req, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic stall, input logic ld, input logic [2:0] ce,
                     input logic wr, input int a, input logic [3:0] bwn,
                     input string req);
    int off;
    @(negedge clk);
    if (adv_prev) begin
      h1_op = h0_op; h1_addr = h0_addr; h1_bm = h0_bm;
      h0_op = p_op;  h0_addr = p_addr;  h0_bm = p_bm;
      if (h1_op == 2) begin
        lcg = lcg * 64'd6364136223846793005 + 64'd1442695040888963407;
        wd  = lcg[63:28];
        for (int b = 0; b < NBYTE; b++)
          if (h1_bm[b]) mdl[h1_addr][b*BYTE_W +: BYTE_W] = wd[b*BYTE_W +: BYTE_W];
      end
    end
    // data phase of the command two enabled edges back
    if (h1_op == 2) begin
      tb_drv = 1'b1; tb_dq = wd;
    end else begin
      tb_drv = 1'b0;
      #1;
      if (h1_op == 1) begin
        if (oe_probe) begin
          oe_n = 1'b1; #1;
          chk(dq == '1, "R8 oe_n high floats bus", dq, '1);
          oe_n = 1'b0; #1;
        end
        chk(dq == mdl[h1_addr], req, dq, mdl[h1_addr]);
      end else begin
        chk(dq == '1, {req, " (bus undriven)"}, dq, '1);
      end
    end
    // present this cycle's command
    cen_n = stall; ce1_n = ce[2]; ce2 = ce[1]; ce3_n = ce[0];
    adv_ld_n = !ld; we_n = !wr; addr = a[ADDR_W-1:0]; bw_n = bwn;
    if (!stall) begin
      if (ld) begin
        p_op = (ce == SEL) ? (wr ? 2 : 1) : 0;
        m_bop = p_op; m_base = a; m_cnt = 0; p_addr = a;
      end else begin
        m_cnt = (m_cnt + 1) & 3;
        off = burst_linear ? (((m_base & 3) + m_cnt) & 3) : ((m_base & 3) ^ m_cnt);
        p_addr = (m_base & ~3) | off;
        p_op = m_bop;
      end
      p_bm = ~bwn;
    end
    adv_prev = !stall;
  endtask

  task automatic wr1(input int a, input string req);
    cyc(0, 1, SEL, 1, a, 4'h0, req);
  endtask
  task automatic wrm(input int a, input logic [3:0] bwn, input string req);
    cyc(0, 1, SEL, 1, a, bwn, req);
  endtask
  task automatic rd1(input int a, input string req);
    cyc(0, 1, SEL, 0, a, 4'h0, req);
  endtask
  task automatic idle(input string req);
    cyc(0, 1, 3'b110, 0, 0, 4'h0, req);
  endtask
  task automatic advc(input string req);
    cyc(0, 0, SEL, 0, 0, 4'h0, req);
  endtask
  task automatic stl(input string req);
    cyc(1, 1, SEL, 1, 7, 4'h0, req);  // ignored write to word 7
  endtask

  initial begin
    rst = 1'b1; cen_n = 1'b0; ce1_n = 1'b1; ce2 = 1'b0; ce3_n = 1'b1;
    adv_ld_n = 1'b0; we_n = 1'b1; bw_n = '1; addr = '0; burst_linear = 1'b1;
    oe_n = 1'b0; tb_drv = 1'b0; tb_dq = '0; oe_probe = 0;
    m_bop = 0; m_base = 0; m_cnt = 0; p_op = 0; p_addr = 0; p_bm = '0;
    h0_op = 0; h0_addr = 0; h0_bm = '0; h1_op = 0; h1_addr = 0; h1_bm = '0;
    adv_prev = 0; wd = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R9: nothing pending after reset
    repeat (3) idle("R9 reset state");

    // R1/R10: fill then stream readback
    for (int a = 0; a < DEPTH; a++) wr1(a, "R10 write fill");
    for (int a = 0; a < DEPTH; a++) rd1(a, "R1 read stream");
    idle("R1"); idle("R1");

    // R2: back-to-back mixes, bypass at distance 1 and 2
    for (int a = 0; a < DEPTH; a++) begin wr1(a, "R2"); rd1(a, "R2 bypass d1"); end
    for (int a = 0; a < 8; a++) begin
      wr1(a, "R2"); idle("R2"); rd1(a, "R2 bypass d2");
      wr1(a + 8, "R2"); wr1(a + 16, "R2"); rd1(a + 8, "R2 bypass d2 mix");
    end
    idle("R2"); idle("R2");

    // R3: every lane mask over a known word, read right after and later
    for (int m = 0; m < 16; m++) begin
      wr1(3, "R3"); wrm(3, m[3:0], "R3"); rd1(3, "R3 lane mask");
      idle("R3"); rd1(3, "R3 lane mask settled");
    end
    idle("R3"); idle("R3");

    // R4: each chip select deasserted on a write
    cyc(0, 1, 3'b110, 1, 5, 4'h0, "R4 ce1_n high");
    cyc(0, 1, 3'b000, 1, 5, 4'h0, "R4 ce2 low");
    cyc(0, 1, 3'b011, 1, 5, 4'h0, "R4 ce3_n high");
    idle("R4"); idle("R4");
    rd1(5, "R4 word unchanged"); idle("R4"); idle("R4");

    // R5: pending write and read complete after deselect
    wr1(6, "R5"); idle("R5"); idle("R5"); idle("R5");
    rd1(6, "R5 pending write kept"); idle("R5 pending read done"); idle("R5");

    // R6: bursts in both orders from every start offset, with wrap
    for (int l = 0; l < 2; l++) begin
      burst_linear = l[0];
      for (int s = 0; s < 4; s++) begin
        cyc(0, 1, SEL, 1, 12 + s, 4'h0, "R6 burst write");
        advc("R6"); advc("R6"); advc("R6");
        cyc(0, 1, SEL, 0, 12 + s, 4'h0, "R6 burst read");
        advc("R6"); advc("R6"); advc("R6"); advc("R6 wrap");
      end
      idle("R6"); advc("R6 advance after deselect"); advc("R6"); advc("R6 no op");
    end
    burst_linear = 1'b1;

    // R7: stalls interleaved with a mix; stalled write to 7 ignored
    wr1(10, "R7"); stl("R7"); stl("R7"); rd1(10, "R7");
    wr1(11, "R7"); stl("R7 hold write data"); rd1(11, "R7");
    rd1(10, "R7"); stl("R7 hold read data"); stl("R7 hold read data");
    idle("R7"); stl("R7"); idle("R7"); idle("R7");

    // R8: asynchronous output enable during read data phases
    oe_probe = 1;
    for (int a = 0; a < 4; a++) rd1(a, "R8 data after oe_n low");
    idle("R8"); idle("R8");
    oe_probe = 0;

    // Final readback: catches any ignored command that reached memory
    for (int a = 0; a < DEPTH; a++) rd1(a, "R7 R4 final readback");
    idle("R1"); idle("R1");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule